// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges every received frame by its 48-bit destination address and returns an accept or drop verdict. Three kinds of filtering can be combined. Promiscuous mode passes everything. Pass-all-multicast mode passes any group address. Hash filtering checks a multicast address against a bin table indexed by a CRC-32 of the address. Unicast addresses, and multicast addresses when hashing is off, are compared exactly against a small table of stations. Entry 0 of that table is the station's own address.

A controller programs the mode word, the hash words and the exact-match entries through a single-cycle write port. The receive path presents the destination address with a one-cycle `da_valid` strobe. The block snapshots the address and the whole configuration, then runs the CRC one address byte per cycle. Exactly eight clock edges later it raises `done_o` for one cycle, with the verdict on `accept_o`. Byte `k` of the address, in wire order, sits at `da[8k+7:8k]`.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `done_o` and `accept_o` are low. The mode word, all hash words and all exact-match entries are zero, so only the all-ones broadcast address is accepted.
- R2: An address is taken at a rising edge where `da_valid` is high and no decision is in flight. `done_o` is high for exactly one cycle, right after the eighth following edge. `accept_o` carries the verdict in that cycle and is low in all other cycles.
- R3: A `da_valid` strobe that arrives while a decision is in flight is ignored and produces no extra `done_o`.
- R4: Mode word (register 0) bit 0 is the promiscuous mode. When it is set, every address is accepted regardless of the other settings.
- R5: The all-ones address is accepted unless mode bit 4 (drop broadcast) is set. In that case it is dropped, unless promiscuous mode is on.
- R6: Mode bit 1 is pass-all-multicast. When it is set, any non-broadcast address whose group bit `da[0]` is 1 is accepted without using the hash table.
- R7: Mode bit 2 turns on hash filtering for non-broadcast group addresses. The CRC-32 is taken in reflected form, starting from all ones, over the six bytes, each byte low bit first. The result is inverted and bit-reversed, and its top n bits form the bin index. Mode field [9:8] selects n: 0 gives 6, 1 gives 7, 2 or 3 gives 8. Index bits above bit 4 pick hash word w (register 8+w), and index bits [4:0] pick the bit within that word. The address is accepted when that bit is 1.
- R8: With hashing on, mode bit 3 (hash-or-exact) also accepts a group address that matches an exact-match entry. Without bit 3, such an address is accepted only through its hash bit.
- R9: Exact-match entry i holds address bits [31:0] in register 16+2i and bits [47:32] in bits [15:0] of register 17+2i. An entry that is all zeros never matches. A unicast address is accepted only on a match. A group address with hashing and pass-all-multicast both off is also decided by exact match.
- R10: A configuration write made while a decision is in flight does not change that decision. It applies to the next address taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register number |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 (first on the wire) in bits [7:0] |
| done_o | output | 1 | One-cycle decision pulse |
| accept_o | output | 1 | Verdict, valid while `done_o` is high |

## Verification
The address is sampled at edge k and the verdict lands after edge k+8. That delay is the snapshot edge, six CRC byte steps, one hit-capture stage and the output register. After the strobe edge, the bench steps through edges k+1 to k+7 and confirms at each falling edge that `done_o` stays low. It reads `done_o` and `accept_o` at the falling edge after edge k+8. It then confirms that the pulse has ended, looking four edges further when a stray strobe was injected. Mid-flight configuration writes are made at edge k+2, so their effect must show only in the next decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int HASH_WORDS = 8;
  localparam int MODE_REG   = 0;
  localparam int HASH_BASE  = 8;
  localparam int PERF_BASE  = 16;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef struct packed {
    logic [1:0] hsize;
    logic       drop_bcast;
    logic       hash_or_exact;
    logic       hash_mc;
    logic       pass_mc;
    logic       promisc;
  } mode_t;

  function automatic mode_t mode_from_word(input logic [31:0] w);
    mode_t m;
    m.promisc       = w[0];
    m.pass_mc       = w[1];
    m.hash_mc       = w[2];
    m.hash_or_exact = w[3];
    m.drop_bcast    = w[4];
    m.hsize         = w[9:8];
    return m;
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // Top eight bits of the bit-reversed inverted CRC, taken from its low byte.
  function automatic logic [7:0] top_rev8(input logic [7:0] inv_low);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[7-i] = inv_low[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_PERF = 4,
  parameter int CFG_AW = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [CFG_AW-1:0]                addr,
  input  logic [31:0]                      wdata,
  output mode_t                            mode_o,
  output logic [HASH_WORDS-1:0][31:0]      hash_o,
  output logic [N_PERF-1:0][47:0]          perf_o
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we && addr == CFG_AW'(MODE_REG)) mode_d = mode_from_word(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    logic        en;
    logic [31:0] q;
    always_comb en = we && (addr == CFG_AW'(HASH_BASE + w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign hash_o[w] = q;
  end

  for (genvar e = 0; e < N_PERF; e++) begin : g_perf
    logic        en_lo, en_hi;
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    always_comb begin
      en_lo = we && (addr == CFG_AW'(PERF_BASE + 2*e));
      en_hi = we && (addr == CFG_AW'(PERF_BASE + 2*e + 1));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (en_lo) lo_q <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (en_hi) hi_q <= wdata[15:0];
    end
    assign perf_o[e] = {hi_q, lo_q};
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match #(
  parameter int N_PERF = 4
) (
  input  logic [47:0]              addr,
  input  logic [N_PERF-1:0][47:0]  table_i,
  output logic                     hit
);
  logic [N_PERF-1:0] ent_hit;

  for (genvar e = 0; e < N_PERF; e++) begin : g_cmp
    always_comb ent_hit[e] = (|table_i[e]) && (table_i[e] == addr);
  end

  assign hit = |ent_hit;
endmodule

// File: rtl/rxf_hash_engine.sv
module rxf_hash_engine
  import rxf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         step,
  input  logic [2:0]                   byte_sel,
  input  logic [47:0]                  da,
  input  logic [1:0]                   hsize,
  input  logic [HASH_WORDS-1:0][31:0]  tbl,
  output logic                         hit
);
  logic [31:0]                   crc_q, crc_d;
  logic [ADDR_BYTES-1:0][7:0]    bytes;
  logic [7:0]                    rev8;
  logic [7:0]                    idx;

  assign bytes = da;

  always_comb begin
    crc_d = crc_q;
    if (load)      crc_d = '1;
    else if (step) crc_d = crc_byte(crc_q, bytes[byte_sel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  always_comb begin
    rev8 = top_rev8(~crc_q[7:0]);
    case (hsize)
      2'd0:    idx = {2'b00, rev8[7:2]};
      2'd1:    idx = {1'b0,  rev8[7:1]};
      default: idx = rev8;
    endcase
    hit = tbl[idx[7:5]][idx[4:0]];
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int N_PERF = 4,
  parameter int CFG_AW = $clog2(PERF_BASE + 2*N_PERF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              done_o,
  output logic              accept_o
);
  localparam logic [2:0] HIT_STAGE  = 3'(ADDR_BYTES);
  localparam logic [2:0] DONE_STAGE = 3'(ADDR_BYTES + 1);

  logic rst_sync_n;

  mode_t                        mode_q;
  logic [HASH_WORDS-1:0][31:0]  hash_live;
  logic [N_PERF-1:0][47:0]      perf_live;

  logic                         busy_q, busy_d;
  logic [2:0]                   cnt_q, cnt_d;
  logic [47:0]                  snap_da_q;
  mode_t                        snap_mode_q;
  logic [HASH_WORDS-1:0][31:0]  snap_hash_q;
  logic                         exact_hit_live, exact_q;
  logic                         hash_hit_live, hash_q;
  logic                         done_q, done_d, accept_q, accept_d;
  logic                         start, crc_step, cap_en, verdict;
  logic                         is_bcast, is_group;

  rxf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxf_cfg_regs #(.N_PERF(N_PERF), .CFG_AW(CFG_AW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .mode_o (mode_q),
    .hash_o (hash_live),
    .perf_o (perf_live)
  );

  rxf_exact_match #(.N_PERF(N_PERF)) u_exact (
    .addr    (da),
    .table_i (perf_live),
    .hit     (exact_hit_live)
  );

  rxf_hash_engine u_hash (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (start),
    .step     (crc_step),
    .byte_sel (cnt_q),
    .da       (snap_da_q),
    .hsize    (snap_mode_q.hsize),
    .tbl      (snap_hash_q),
    .hit      (hash_hit_live)
  );

  always_comb begin
    start    = da_valid && !busy_q;
    crc_step = busy_q && (cnt_q < HIT_STAGE);
    cap_en   = busy_q && (cnt_q == HIT_STAGE);
  end

  always_comb begin
    is_bcast = &snap_da_q;
    is_group = snap_da_q[0];
    if (snap_mode_q.promisc)      verdict = 1'b1;
    else if (is_bcast)            verdict = !snap_mode_q.drop_bcast;
    else if (is_group) begin
      if (snap_mode_q.pass_mc)      verdict = 1'b1;
      else if (snap_mode_q.hash_mc) verdict = hash_q || (snap_mode_q.hash_or_exact && exact_q);
      else                          verdict = exact_q;
    end
    else                          verdict = exact_q;
  end

  always_comb begin
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    accept_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 3'd1;
      if (cnt_q == DONE_STAGE) begin
        busy_d   = 1'b0;
        cnt_d    = '0;
        done_d   = 1'b1;
        accept_d = verdict;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      accept_q <= accept_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      snap_da_q   <= '0;
      snap_mode_q <= '0;
      snap_hash_q <= '0;
      exact_q     <= 1'b0;
    end else if (start) begin
      snap_da_q   <= da;
      snap_mode_q <= mode_q;
      snap_hash_q <= hash_live;
      exact_q     <= exact_hit_live;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  hash_q <= 1'b0;
    else if (cap_en)  hash_q <= hash_hit_live;
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        da_valid,
  input logic [47:0] da,
  input mode_t       live_mode,
  input logic        done_o,
  input logic        accept_o
);
  logic [3:0] c_q;
  logic       s_promisc, s_drop, s_bcast;
  logic       go;

  assign go = da_valid && (c_q == 4'd0 || c_q == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            c_q <= '0;
    else if (go)           c_q <= 4'd1;
    else if (c_q == 4'd9)  c_q <= '0;
    else if (c_q != 4'd0)  c_q <= c_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_promisc <= 1'b0;
      s_drop    <= 1'b0;
      s_bcast   <= 1'b0;
    end else if (go) begin
      s_promisc <= live_mode.promisc;
      s_drop    <= live_mode.drop_bcast;
      s_bcast   <= &da;
    end
  end

  AST_DONE_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == (c_q == 4'd9)); // R2 R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> done_o); // R2
  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && s_promisc) |-> accept_o); // R4
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && s_bcast && !s_drop) |-> accept_o); // R5
  AST_BCAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && s_bcast && s_drop && !s_promisc) |-> !accept_o); // R5
endmodule

bind rx_dest_filter rxf_checker u_rxf_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .da_valid  (da_valid),
  .da        (da),
  .live_mode (mode_q),
  .done_o    (done_o),
  .accept_o  (accept_o)
);

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;
  localparam int NP = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          da_valid;
  logic [47:0]   da;
  logic          done_o, accept_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mode_s;
  logic [31:0] hash_s [8];
  logic [47:0] perf_s [NP];

  always #2.5 clk = ~clk;

  rx_dest_filter #(.N_PERF(NP), .CFG_AW(AW)) u_rx_dest_filter (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .da_valid, .da, .done_o, .accept_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c;
  endfunction

  function automatic bit ref_hash(input logic [47:0] a, input logic [1:0] hs);
    logic [31:0] x = ~ref_crc(a);
    int n = (hs == 2'd0) ? 6 : (hs == 2'd1) ? 7 : 8;
    int idx = 0;
    for (int m = 0; m < n; m++) idx = idx | (int'(x[n-1-m]) << m);
    return hash_s[idx >> 5][idx & 31];
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    bit pm = 0;
    for (int e = 0; e < NP; e++) if (perf_s[e] != 0 && perf_s[e] == a) pm = 1;
    if (mode_s[0]) return 1;
    if (a == '1) return !mode_s[4];
    if (a[0]) begin
      if (mode_s[1]) return 1;
      if (mode_s[2]) return ref_hash(a, mode_s[9:8]) || (mode_s[3] && pm);
      return pm;
    end
    return pm;
  endfunction

  task automatic shadow(input int ad, input logic [31:0] d);
    if (ad == 0) mode_s = d;
    else if (ad >= 8 && ad < 16) hash_s[ad-8] = d;
    else if (ad >= 16 && ad < 16 + 2*NP) begin
      if ((ad - 16) % 2 == 0) perf_s[(ad-16)/2][31:0] = d;
      else perf_s[(ad-16)/2][47:32] = d[15:0];
    end
  endtask

  task automatic cfg_write(input int ad, input logic [31:0] d);
    cfg_we = 1; cfg_addr = AW'(ad); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    shadow(ad, d);
  endtask

  task automatic set_entry(input int e, input logic [47:0] a);
    cfg_write(16 + 2*e, a[31:0]);
    cfg_write(17 + 2*e, {16'h0, a[47:32]});
  endtask

  // kind 0: plain; 1: config write mid-flight (R10); 2: stray strobe mid-flight (R3)
  task automatic run(input logic [47:0] a, input string req, input int kind,
                     input int mid_ad, input logic [31:0] mid_d);
    bit exp = ref_accept(a);
    bit early = 0;
    bit late = 0;
    da_valid = 1; da = a;
    @(posedge clk); @(negedge clk);
    da_valid = 0;
    for (int i = 1; i <= 7; i++) begin
      if (kind == 1 && i == 2) begin
        cfg_we = 1; cfg_addr = AW'(mid_ad); cfg_wdata = mid_d;
      end
      if (kind == 2 && i == 3) begin
        da_valid = 1; da = ~a;
      end
      @(posedge clk); @(negedge clk);
      if (kind == 1 && i == 2) shadow(mid_ad, mid_d);
      cfg_we = 0; da_valid = 0;
      if (done_o) early = 1;
    end
    check(!early, {req, " R2 done early"}, int'(early), 0);
    @(posedge clk); @(negedge clk);
    check(done_o == 1'b1, {req, " R2 done due"}, int'(done_o), 1);
    check(accept_o == exp, req, int'(accept_o), int'(exp));
    for (int i = 0; i < ((kind == 2) ? 4 : 1); i++) begin
      @(posedge clk); @(negedge clk);
      if (done_o || accept_o) late = 1;
    end
    check(!late, {req, (kind == 2) ? " R3 stray strobe" : " R2 pulse width"}, int'(late), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; da_valid = 0; da = '0;
    mode_s = 0;
    for (int w = 0; w < 8; w++) hash_s[w] = 0;
    for (int e = 0; e < NP; e++) perf_s[e] = 0;
    repeat (4) @(negedge clk);
    check(done_o == 0 && accept_o == 0, "R1 outputs in reset", int'({done_o, accept_o}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(done_o == 0 && accept_o == 0, "R1 outputs after reset", int'({done_o, accept_o}), 0);

    // R1: default configuration
    run(48'hFFFF_FFFF_FFFF, "R1 bcast default", 0, 0, 0);
    run(48'h0000_0000_0000, "R1 R9 zero addr vs cleared table", 0, 0, 0);
    run(48'h1234_5678_9A01, "R1 group default drop", 0, 0, 0);

    // table setup (R9)
    set_entry(0, 48'h6655_4433_2210);
    set_entry(1, 48'h0000_005E_0001);
    set_entry(2, 48'hABCD_EF01_2346);
    for (int w = 0; w < 8; w++) cfg_write(8 + w, (32'(w) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3);

    // mode sweep over the five control bits (R4 R5 R6 R8 R9)
    for (int m = 0; m < 32; m++) begin
      cfg_write(0, 32'(m));
      run(48'hFFFF_FFFF_FFFF, "R5 bcast sweep", 0, 0, 0);
      run(48'h6655_4433_2210, "R9 own station", 0, 0, 0);
      run(48'hABCD_EF01_2346, "R9 extra entry", 0, 0, 0);
      run(48'h0000_005E_0001, "R8 group exact", 0, 0, 0);
      run(48'h1111_1111_1112, "R9 unknown unicast", 0, 0, 0);
      run(48'h2222_2222_2223, "R6 unknown group", 0, 0, 0);
      run(48'h0000_0000_0000, "R4 zero addr", 0, 0, 0);
    end

    // hash sweep over the three index widths (R7)
    for (int hs = 0; hs < 4; hs++) begin
      cfg_write(0, 32'h4 | (32'(hs) << 8));
      for (int j = 0; j < 48; j++) begin
        logic [47:0] a = {32'(j) * 32'h0100_0193 + 32'h1234_5678, 8'(j * 37), 8'(j * 2 + 1)};
        run(a, "R7 hash bin", 0, 0, 0);
      end
    end

    // R10: in-flight decision keeps its configuration
    cfg_write(0, 32'h0);
    run(48'h1111_1111_1112, "R10 before promisc", 1, 0, 32'h1);
    run(48'h1111_1111_1112, "R10 after promisc", 0, 0, 0);
    run(48'h3333_3333_3332, "R10 entry written mid-flight", 1, 16 + 2*3, 32'h3333_3332);
    cfg_write(17 + 2*3, 32'h0000_3333);
    cfg_write(0, 32'h0);
    run(48'h3333_3333_3332, "R10 entry now active", 0, 0, 0);

    // R3: stray strobe while busy
    run(48'h6655_4433_2210, "R3 busy strobe", 2, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule